// File: doc/BRIEF.md
# SDRAM Single-Beat Write Sequencer with Auto Precharge

This block turns one host write request into the command sequence a single-data-rate SDRAM needs for an isolated one-beat write that closes its own row. A request carries bank, row, column and a data word. The block opens the row with ACTIVE and waits for the row-to-column delay. It then issues WRITE with the auto-precharge address bit set and the data beat on the bus in the same cycle. After that it keeps the host out until a new ACTIVE is legal. Every timing limit is a parameter in picoseconds. Each one becomes a cycle count by ceiling division by the clock-period parameter.

The WRITE is placed at W cycles after ACTIVE, where W = max(ceil(tRCD), ceil(tRAS_min) - ceil(tWR)). This keeps the internal precharge, which starts tWR after the WRITE, from cutting the row's minimum active time short. The next ACTIVE may come at N cycles after the previous one, where N = max(ceil(tRC), W + ceil(tWR) + ceil(tRP)).

The controller has five states: IDLE, OPEN (ACTIVE decided), RCD_WAIT, WRITE and RECOVER. It moves between them as follows:
- IDLE goes to OPEN on an accepted request.
- OPEN and RCD_WAIT go to WRITE once the WRITE slot is reached. Until then OPEN goes to RCD_WAIT and RCD_WAIT stays where it is.
- WRITE goes to IDLE if the re-open slot is already due. Otherwise it goes to RECOVER.
- RECOVER goes back to IDLE when the re-open slot is due.

The memory pins are registered, so each command reaches the pins one cycle after the state that selects it.

Top module: `sdram_wr_ap_seq`

## Requirements
- R1: After reset the pins carry NOP, `sd_cke` is 1, `sd_dq_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: The command encodings on {cs_n, ras_n, cas_n, we_n} are NOP = 0111, ACTIVE = 0011 and WRITE = 0100. Every cycle that is neither ACTIVE nor WRITE carries NOP with `sd_dq_oe` = 0. `sd_cke` stays 1 and `sd_dqm` stays 0 in every cycle.
- R3: ACTIVE drives the captured row on `sd_addr` and the captured bank on `sd_ba`.
- R4: WRITE drives the column on `sd_addr[8:0]` and sets `sd_addr[10]` = 1 (auto precharge). It drives every other address bit to 0. It carries the same bank as the ACTIVE and places the data word on `sd_dq` with `sd_dq_oe` = 1.
- R5: WRITE appears exactly W cycles after its ACTIVE. This keeps the row open for at least tRAS_min and at most tRAS_max.
- R6: Consecutive ACTIVE commands are at least N cycles apart. When a request is already waiting as the block becomes idle, the gap is exactly N.
- R7: `req_ready` is 1 only in IDLE, and only once the re-open slot is reached. A request is taken on `req_valid && req_ready`. Changes to the request inputs after that edge do not alter the pins.
- R8: `done` is a one-cycle pulse in the cycle `req_ready` returns high after a write. That cycle is N-2 cycles after the ACTIVE on the pins.
- R9: ACTIVE reaches the pins two cycles after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and timing satisfied |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_data | input | DATA_W | Data word to write |
| done | output | 1 | One-cycle pulse when a new ACTIVE becomes legal |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | DATA_W/8 | Byte masks |

## Verification
The bench runs two parameter sets. In the first, the row-to-column delay fixes the WRITE slot. In the second, the slower-grade minimum active time pushes the WRITE later, so an off-by-one in either placement rule shows up as a wrong ACTIVE-to-WRITE gap. Requests arrive back-to-back, which tests exact re-open spacing. They also arrive after random idle gaps, which tests the minimum spacing and the ready/done return. Directed all-ones and all-zeros fields show that the column never leaks into bits 9, 11 and 12 and that the auto-precharge bit is always set. Scrambling the request inputs right after acceptance shows that the captured request is what reaches the pins.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_RCD_WAIT,
        ST_WRITE,
        ST_RECOVER
    } wr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WR
    } sd_cmd_e;

    // ceiling of a picosecond interval over the clock period
    function automatic int cyc_of(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wr_timer.sv
module sdram_wr_timer #(
    parameter int W_CYC = 2,
    parameter int N_CYC = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             go_wr,
    output logic             go_idle
);
    localparam logic [CNT_W-1:0] WR_AT   = CNT_W'(W_CYC - 1);
    localparam logic [CNT_W-1:0] IDLE_AT = CNT_W'(N_CYC - 2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

    // decisions made one cycle ahead of the slot they select
    assign go_wr   = (cnt >= WR_AT);
    assign go_idle = (cnt >= IDLE_AT);

endmodule

// File: rtl/sdram_wr_fsm.sv
module sdram_wr_fsm
    import sdram_wr_pkg::*;
#(
    parameter int RCD_CYC    = 2,
    parameter int RASMIN_CYC = 4,
    parameter int RASMAX_CYC = 12000,
    parameter int WR_CYC     = 2,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             go_wr,
    input  logic             go_idle,
    input  logic [CNT_W-1:0] cnt,
    output logic             ready,
    output logic             accept,
    output logic             run,
    output sd_cmd_e          cmd,
    output logic             done
);
    wr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state != ST_IDLE) && (state_nx == ST_IDLE);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_OPEN;
            ST_OPEN:     state_nx = go_wr ? ST_WRITE : ST_RCD_WAIT;
            ST_RCD_WAIT: if (go_wr) state_nx = ST_WRITE;
            ST_WRITE:    state_nx = go_idle ? ST_IDLE : ST_RECOVER;
            ST_RECOVER:  if (go_idle) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = (state == ST_IDLE);
        accept = ready && req_valid;
        run    = (state != ST_IDLE);
        unique case (state)
            ST_OPEN:  cmd = CMD_ACT;
            ST_WRITE: cmd = CMD_WR;
            default:  cmd = CMD_NOP;
        endcase
    end

    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_OPEN)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> (int'(cnt) >= RCD_CYC)); // R5
    AST_RAS_MIN_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> (int'(cnt) + WR_CYC >= RASMIN_CYC)); // R5
    AST_RAS_MAX_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> (int'(cnt) + WR_CYC <= RASMAX_CYC)); // R5

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
    import sdram_wr_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  sd_cmd_e           cmd,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_data,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe
);
    logic [BANK_W-1:0] cap_bank;
    logic [ROW_W-1:0]  cap_row;
    logic [COL_W-1:0]  cap_col;
    logic [DATA_W-1:0] cap_data;
    logic [ROW_W-1:0]  wr_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bank <= '0;
            cap_row  <= '0;
            cap_col  <= '0;
            cap_data <= '0;
        end else if (accept) begin
            cap_bank <= in_bank;
            cap_row  <= in_row;
            cap_col  <= in_col;
            cap_data <= in_data;
        end
    end

    always_comb begin
        wr_addr                = '0;
        wr_addr[COL_W-1:0]     = cap_col;
        wr_addr[AP_BIT]        = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
            ba    <= '0;
            addr  <= '0;
            dq    <= '0;
            dq_oe <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_ACT: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0011;
                    ba    <= cap_bank;
                    addr  <= cap_row;
                    dq    <= '0;
                    dq_oe <= 1'b0;
                end
                CMD_WR: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0100;
                    ba    <= cap_bank;
                    addr  <= wr_addr;
                    dq    <= cap_data;
                    dq_oe <= 1'b1;
                end
                default: begin
                    {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
                    ba    <= '0;
                    addr  <= '0;
                    dq    <= '0;
                    dq_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_wr_ap_seq.sv
module sdram_wr_ap_seq
    import sdram_wr_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int ROW_W       = 13,
    parameter int COL_W       = 9,
    parameter int DATA_W      = 16,
    parameter int AP_BIT      = 10,
    parameter int CLK_PS      = 10000,
    parameter int RCD_PS      = 15000,
    parameter int RAS_MIN_PS  = 37000,
    parameter int RAS_MAX_PS  = 120000000,
    parameter int RC_PS       = 60000,
    parameter int RP_PS       = 15000,
    parameter int WR_EXTRA_PS = 7000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic [DATA_W-1:0]     req_data,
    output logic                  done,
    output logic                  sd_cke,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [BANK_W-1:0]     sd_ba,
    output logic [ROW_W-1:0]      sd_addr,
    output logic [DATA_W-1:0]     sd_dq,
    output logic                  sd_dq_oe,
    output logic [DATA_W/8-1:0]   sd_dqm
);
    localparam int RCD_CYC    = cyc_of(RCD_PS, CLK_PS);
    localparam int RASMIN_CYC = cyc_of(RAS_MIN_PS, CLK_PS);
    localparam int RASMAX_CYC = cyc_of(RAS_MAX_PS, CLK_PS);
    localparam int RC_CYC     = cyc_of(RC_PS, CLK_PS);
    localparam int RP_CYC     = cyc_of(RP_PS, CLK_PS);
    localparam int WR_CYC     = cyc_of(CLK_PS + WR_EXTRA_PS, CLK_PS);
    localparam int W_CYC      = imax(RCD_CYC, RASMIN_CYC - WR_CYC);
    localparam int N_CYC      = imax(RC_CYC, W_CYC + WR_CYC + RP_CYC);
    localparam int CNT_W      = $clog2(RASMAX_CYC + 2);
    localparam int GAP_W      = $clog2(N_CYC + 2);

    logic             accept, run, go_wr, go_idle;
    logic [CNT_W-1:0] cnt;
    sd_cmd_e          cmd;

    sdram_wr_timer #(
        .W_CYC (W_CYC),
        .N_CYC (N_CYC),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .run     (run),
        .cnt     (cnt),
        .go_wr   (go_wr),
        .go_idle (go_idle)
    );

    sdram_wr_fsm #(
        .RCD_CYC    (RCD_CYC),
        .RASMIN_CYC (RASMIN_CYC),
        .RASMAX_CYC (RASMAX_CYC),
        .WR_CYC     (WR_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .go_wr     (go_wr),
        .go_idle   (go_idle),
        .cnt       (cnt),
        .ready     (req_ready),
        .accept    (accept),
        .run       (run),
        .cmd       (cmd),
        .done      (done)
    );

    sdram_wr_pins #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .AP_BIT (AP_BIT)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cmd     (cmd),
        .in_bank (req_bank),
        .in_row  (req_row),
        .in_col  (req_col),
        .in_data (req_data),
        .cs_n    (sd_cs_n),
        .ras_n   (sd_ras_n),
        .cas_n   (sd_cas_n),
        .we_n    (sd_we_n),
        .ba      (sd_ba),
        .addr    (sd_addr),
        .dq      (sd_dq),
        .dq_oe   (sd_dq_oe)
    );

    assign sd_cke = 1'b1;
    assign sd_dqm = '0;

    // pin-level spacing monitor
    logic             pin_act, pin_wr, seen_act;
    logic [GAP_W-1:0] gap_q;

    assign pin_act = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011);
    assign pin_wr  = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q    <= '0;
            seen_act <= 1'b0;
        end else if (pin_act) begin
            gap_q    <= GAP_W'(1);
            seen_act <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q    <= gap_q + 1'b1;
        end
    end

    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_act && seen_act) |-> (int'(gap_q) >= N_CYC)); // R6
    AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |-> (seen_act && int'(gap_q) == W_CYC)); // R5
    AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |-> (sd_addr[AP_BIT] && sd_dq_oe)); // R4
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_act && !pin_wr) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !sd_dq_oe)); // R2
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R8

endmodule

// File: tb/test_sdram_wr_ap_seq.sv
module wr_seq_lane #(
    parameter int CLK_PS      = 10000,
    parameter int RCD_PS      = 15000,
    parameter int RAS_MIN_PS  = 37000,
    parameter int RC_PS       = 60000,
    parameter int RP_PS       = 15000,
    parameter int WR_EXTRA_PS = 7000,
    parameter int SEED        = 1,
    parameter int NREQ        = 40
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic finished
);
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int exp_w();
        int rcd, ras, wr;
        rcd = cdiv(RCD_PS, CLK_PS);
        ras = cdiv(RAS_MIN_PS, CLK_PS);
        wr  = cdiv(CLK_PS + WR_EXTRA_PS, CLK_PS);
        return (rcd > ras - wr) ? rcd : ras - wr;
    endfunction
    function automatic int exp_n();
        int rc, alt;
        rc  = cdiv(RC_PS, CLK_PS);
        alt = exp_w() + cdiv(CLK_PS + WR_EXTRA_PS, CLK_PS) + cdiv(RP_PS, CLK_PS);
        return (rc > alt) ? rc : alt;
    endfunction
    localparam int EW = exp_w();
    localparam int EN = exp_n();

    logic        req_valid, req_ready, done;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [8:0]  req_col;
    logic [15:0] req_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq;

    sdram_wr_ap_seq #(
        .CLK_PS (CLK_PS), .RCD_PS (RCD_PS), .RAS_MIN_PS (RAS_MIN_PS),
        .RC_PS (RC_PS), .RP_PS (RP_PS), .WR_EXTRA_PS (WR_EXTRA_PS)
    ) i_sdram_wr_ap_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col), .req_data (req_data),
        .done (done), .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba), .sd_addr (sd_addr),
        .sd_dq (sd_dq), .sd_dq_oe (sd_dq_oe), .sd_dqm (sd_dqm)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [1:0]  q_ba  [64];
    logic [12:0] q_row [64];
    logic [8:0]  q_col [64];
    logic [15:0] q_dat [64];
    int          q_acc [64];
    bit          q_wait[64];
    int wp = 0, rp = 0;
    bit mon_on = 0;

    initial begin n_chk = 0; n_fail = 0; finished = 0; end

    task automatic chk(input string tag, input bit ok, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, expv, cyc);
        end
    endtask

    // stimulus
    initial begin
        req_valid = 0; req_bank = 0; req_row = 0; req_col = 0; req_data = 0;
        void'($urandom(SEED));
        wait (rst_n === 1'b1);
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk("R1 cke", sd_cke == 1'b1, sd_cke, 1);
        chk("R1 dq_oe", sd_dq_oe == 1'b0, sd_dq_oe, 0);
        chk("R1 ready", req_ready == 1'b1, req_ready, 1);
        chk("R1 done", done == 1'b0, done, 0);
        mon_on = 1;
        for (int i = 0; i < NREQ; i++) begin
            bit waited;
            int gap;
            req_valid = 1;
            if (i == 0) begin
                req_bank = '1; req_row = '1; req_col = '1; req_data = '1;
            end else if (i == 1) begin
                req_bank = '0; req_row = '0; req_col = '0; req_data = '0;
            end else begin
                req_bank = 2'($urandom); req_row = 13'($urandom);
                req_col = 9'($urandom); req_data = 16'($urandom);
            end
            waited = !req_ready;
            while (!req_ready) @(negedge clk);
            q_ba[wp % 64] = req_bank; q_row[wp % 64] = req_row;
            q_col[wp % 64] = req_col; q_dat[wp % 64] = req_data;
            q_acc[wp % 64] = cyc; q_wait[wp % 64] = waited;
            wp++;
            @(negedge clk);
            req_valid = 0;
            // R7: scramble inputs after acceptance
            req_bank = ~q_ba[(wp - 1) % 64]; req_row = ~q_row[(wp - 1) % 64];
            req_col = ~q_col[(wp - 1) % 64]; req_data = ~q_dat[(wp - 1) % 64];
            gap = (i % 3 == 0) ? 0 : int'($urandom_range(0, 12));
            repeat (gap) @(negedge clk);
        end
        while (rp != wp || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        finished = 1;
    end

    // monitor
    int  last_act = 0;
    bit  have_act = 0;
    logic rdy_prev = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (sd_cke !== 1'b1 || sd_dqm !== 2'b00)
                chk("R2 cke/dqm", 0, {sd_cke, sd_dqm}, 3'b100);
            if (c == 4'b0011) begin
                chk("R3 bank", sd_ba == q_ba[rp % 64], sd_ba, q_ba[rp % 64]);
                chk("R3 row", sd_addr == q_row[rp % 64], sd_addr, q_row[rp % 64]);
                chk("R9 latency", cyc == q_acc[rp % 64] + 2, cyc, q_acc[rp % 64] + 2);
                if (have_act) begin
                    if (q_wait[rp % 64])
                        chk("R6 exact gap", cyc - last_act == EN, cyc - last_act, EN);
                    else
                        chk("R6 min gap", cyc - last_act >= EN, cyc - last_act, EN);
                end
                last_act = cyc;
                have_act = 1;
            end else if (c == 4'b0100) begin
                logic [12:0] ea;
                ea = {4'b0010, q_col[rp % 64]};
                chk("R4 addr", sd_addr == ea, sd_addr, ea);
                chk("R4 bank", sd_ba == q_ba[rp % 64], sd_ba, q_ba[rp % 64]);
                chk("R4 data", sd_dq == q_dat[rp % 64] && sd_dq_oe, sd_dq, q_dat[rp % 64]);
                chk("R5 slot", have_act && cyc - last_act == EW, cyc - last_act, EW);
                rp++;
            end else if (c != 4'b0111 || sd_dq_oe) begin
                chk("R2 nop", 0, {c, sd_dq_oe}, 5'b01110);
            end
            if (req_ready && have_act)
                chk("R7 ready early", cyc - last_act >= EN - 2, cyc - last_act, EN - 2);
            if (done || (req_ready && !rdy_prev)) begin
                chk("R8 done pulse", done == (req_ready && !rdy_prev), done, req_ready && !rdy_prev);
                if (done) chk("R8 done slot", cyc - last_act == EN - 2, cyc - last_act, EN - 2);
            end
            rdy_prev = req_ready;
        end
    end
endmodule

module test_sdram_wr_ap_seq;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    int   c_a, f_a, c_b, f_b;
    logic fin_a, fin_b;

    // fast grade: row-to-column delay sets the WRITE slot
    wr_seq_lane #(.SEED(11)) u_fast (
        .clk (clk), .rst_n (rst_n), .n_chk (c_a), .n_fail (f_a), .finished (fin_a));

    // slow grade at its own period: minimum active time sets the WRITE slot
    wr_seq_lane #(.CLK_PS(7500), .RCD_PS(20000), .RAS_MIN_PS(44000), .RC_PS(66000),
                  .RP_PS(20000), .WR_EXTRA_PS(7500), .SEED(23)) u_slow (
        .clk (clk), .rst_n (rst_n), .n_chk (c_b), .n_fail (f_b), .finished (fin_b));

    initial begin
        int total, failed;
        bit timed_out;
        timed_out = 0;
        repeat (4) @(posedge clk);
        rst_n = 1;
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (fin_a && fin_b) break;
        end
        if (!(fin_a && fin_b)) timed_out = 1;
        total  = c_a + c_b;
        failed = f_a + f_b;
        if (timed_out) begin
            total++;
            failed++;
            $display("FAIL watchdog: got running expected finished");
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule